// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block holds the sticky event flags of a metering front end and turns them into a single active-low interrupt level. Pulses from the measurement side latch into a 24-bit flag register. The host clears flags by writing ones to them, and writing zeros leaves flags untouched. A 24-bit enable register selects which flags may pull the interrupt line low. A flag latches whether or not it is enabled, so the host can always poll it.

Two flags behave differently from the others. The command-error flag rests at 1 and means "active" when it is 0. Host writes never change it, and only a port re-initialisation pulse returns it to 1. The energy-watchdog flag is set by an internal counter that measures the time since the last energy-register read. A write-one clears this flag only after a read has restarted that counter.

Top module: `irqsc_top`

## Requirements
- R1: After reset, statusRd is 0x000001, maskRd is 0x000000 and irqN is 1.
- R2: An evtPulse bit at one of the event positions (23, 22, 21, 19, 17, 16, 15..11, 4..2; mask 0xEBF81C) sets the same statusRd bit one cycle later, whatever maskRd holds. evtPulse bits at other positions have no effect, and the reserved status bits (20, 18, 10..6, 1) always read 0.
- R3: A write with regSel=0 clears each status bit at a position where wrData is 1, and leaves bits where wrData is 0 unchanged.
- R4: If an event and a write-one-to-clear reach the same bit in the same cycle, the bit stays set.
- R5: A write with regSel=1 loads all 24 bits of wrData into maskRd.
- R6: irqN is 0 exactly when, in the previous cycle, some active status bit had its mask bit at 1. It therefore lags the status and mask registers by one cycle.
- R7: Status bit 0 goes to 0 on badCmd, ignores every host write, and returns to 1 on portInit. If badCmd and portInit arrive in the same cycle, badCmd wins.
- R8: Bit 0 counts as active for the interrupt when it is 0. All other bits count as active when they are 1.
- R9: Status bit 5 sets one cycle after WDOG_LIMIT consecutive clock edges pass without an energyRd pulse. Each energyRd pulse restarts the count from zero.
- R10: A write-one to bit 5 clears it only if energyRd has pulsed since the timeout. Otherwise the bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Host write strobe |
| regSel | input | 1 | Write target: 0 status, 1 mask |
| wrData | input | 24 | Host write data |
| evtPulse | input | 24 | Per-bit event pulses |
| badCmd | input | 1 | Invalid command seen |
| portInit | input | 1 | Serial port re-initialised |
| energyRd | input | 1 | Energy register was read |
| statusRd | output | 24 | Status register contents |
| maskRd | output | 24 | Mask register contents |
| irqN | output | 1 | Interrupt, active low, registered |

## Verification
Every one of the 24 event positions is pulsed on its own. This separates real event bits from reserved and special positions, and each pulse is followed by a write-all-ones clear to confirm that the special flags survive it. A second sweep enables one mask bit at a time, which shows which single position drives irqN and confirms its one-cycle lag. Partial-pattern clears, a simultaneous set and clear, and the badCmd/portInit orderings test the write-one-to-clear rules. A short watchdog limit lets the bench time the timeout edge exactly and check clear-before-read against clear-after-read.

// File: rtl/irqsc_pkg.sv
package irqsc_pkg;
  localparam int STAT_W  = 24;
  localparam int IC_BIT  = 0;
  localparam int WDT_BIT = 5;
  // Implemented bits and bits settable by an event pulse
  localparam logic [STAT_W-1:0] VALID_MASK = 24'hEBF83D;
  localparam logic [STAT_W-1:0] EVT_MASK   = 24'hEBF81C;

  typedef struct packed {
    logic statWr;
    logic maskWr;
    logic wdtTimeout;
    logic icFail;
    logic icRestore;
  } irqsc_strb_t;
endpackage

// File: rtl/irqsc_ctrl.sv
module irqsc_ctrl
  import irqsc_pkg::*;
#(
  parameter int WDOG_LIMIT = 20480000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regSel,
  input  logic        badCmd,
  input  logic        portInit,
  input  logic        energyRd,
  output irqsc_strb_t strb
);
  localparam int CNT_W = $clog2(WDOG_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WDOG_LIMIT);

  logic [CNT_W-1:0] wdCnt;
  logic             timedOut;

  assign timedOut = (wdCnt == CNT_MAX);

  // Read-free cycle counter, saturating at the limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         wdCnt <= '0;
    else if (energyRd) wdCnt <= '0;
    else if (!timedOut) wdCnt <= wdCnt + 1'b1;
  end

  always_comb begin
    strb.statWr     = regWrEn && !regSel;
    strb.maskWr     = regWrEn && regSel;
    strb.wdtTimeout = timedOut;
    strb.icFail     = badCmd;
    strb.icRestore  = portInit;
  end

  a_r9_read_restarts: assert property (@(posedge clk) disable iff (!rstN)
    energyRd |=> (wdCnt == '0));
  a_r9_timeout_holds: assert property (@(posedge clk) disable iff (!rstN)
    (timedOut && !energyRd) |=> strb.wdtTimeout);
  a_r9_no_read_counts: assert property (@(posedge clk) disable iff (!rstN)
    (!energyRd && !timedOut) |=> (wdCnt == $past(wdCnt) + 1'b1));
endmodule

// File: rtl/irqsc_dpath.sv
module irqsc_dpath
  import irqsc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  irqsc_strb_t       strb,
  input  logic [STAT_W-1:0] wrData,
  input  logic [STAT_W-1:0] evtPulse,
  output logic [STAT_W-1:0] statusQ,
  output logic [STAT_W-1:0] maskQ,
  output logic              irqN
);
  logic [STAT_W-1:0] clrVec;
  logic [STAT_W-1:0] activeVec;

  assign clrVec = strb.statWr ? wrData : '0;

  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    if (b == IC_BIT) begin : g_ic
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               statusQ[b] <= 1'b1;
        else if (strb.icFail)    statusQ[b] <= 1'b0;
        else if (strb.icRestore) statusQ[b] <= 1'b1;
      end
      assign activeVec[b] = ~statusQ[b];
    end else if (b == WDT_BIT) begin : g_wdt
      // The timeout stays asserted until a read, which blocks an early clear
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) statusQ[b] <= 1'b0;
        else       statusQ[b] <= strb.wdtTimeout | (statusQ[b] & ~clrVec[b]);
      end
      assign activeVec[b] = statusQ[b];
    end else if (EVT_MASK[b]) begin : g_evt
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) statusQ[b] <= 1'b0;
        else       statusQ[b] <= evtPulse[b] | (statusQ[b] & ~clrVec[b]);
      end
      assign activeVec[b] = statusQ[b];
    end else begin : g_rsvd
      assign statusQ[b]   = 1'b0;
      assign activeVec[b] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            maskQ <= '0;
    else if (strb.maskWr) maskQ <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqN <= 1'b1;
    else       irqN <= ~|(activeVec & maskQ);
  end

  a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rstN)
    |(evtPulse & EVT_MASK) |=>
      ((statusQ & $past(evtPulse & EVT_MASK)) == $past(evtPulse & EVT_MASK)));
  a_r2_ignored_pos: assert property (@(posedge clk) disable iff (!rstN)
    |(evtPulse & ~VALID_MASK) |=> ((statusQ & ~VALID_MASK) == '0));
  a_r3_w1c: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statWr && evtPulse == '0 && !strb.wdtTimeout) |=>
      ((statusQ & $past(wrData) & ~VALID_MASK[IC_BIT]) == '0));
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statWr && evtPulse[STAT_W-1] && wrData[STAT_W-1]) |=> statusQ[STAT_W-1]);
  a_r5_mask_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskWr |=> (maskQ == $past(wrData)));
  a_r6_quiet_when_masked: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |=> irqN);
  a_r7_ic_ignores_writes: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.icFail && !strb.icRestore) |=> $stable(statusQ[IC_BIT]));
  a_r7_fail_wins: assert property (@(posedge clk) disable iff (!rstN)
    strb.icFail |=> !statusQ[IC_BIT]);
  a_r10_wdt_held: assert property (@(posedge clk) disable iff (!rstN)
    strb.wdtTimeout |=> statusQ[WDT_BIT]);
endmodule

// File: rtl/irqsc_top.sv
module irqsc_top
  import irqsc_pkg::*;
#(
  parameter int WDOG_LIMIT = 20480000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [STAT_W-1:0] wrData,
  input  logic [STAT_W-1:0] evtPulse,
  input  logic              badCmd,
  input  logic              portInit,
  input  logic              energyRd,
  output logic [STAT_W-1:0] statusRd,
  output logic [STAT_W-1:0] maskRd,
  output logic              irqN
);
  irqsc_strb_t strb;

  irqsc_ctrl #(.WDOG_LIMIT(WDOG_LIMIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .badCmd(badCmd), .portInit(portInit), .energyRd(energyRd), .strb(strb)
  );

  irqsc_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .evtPulse(evtPulse), .statusQ(statusRd), .maskQ(maskRd), .irqN(irqN)
  );

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (irqN && maskRd == '0));
endmodule

// File: tb/irqsc_top_tb.sv
module irqsc_top_tb;
  localparam int LIMIT = 20;
  localparam logic [23:0] EVT = 24'hEBF81C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [23:0] wrData = '0;
  logic [23:0] evtPulse = '0;
  logic        badCmd = 1'b0;
  logic        portInit = 1'b0;
  logic        kaRd = 1'b0;
  logic        tRd = 1'b0;
  logic        wdKeep = 1'b1;
  logic        energyRd;
  logic [23:0] statusRd;
  logic [23:0] maskRd;
  logic        irqN;
  int          kaCnt = 0;
  int          nChk = 0;
  int          nErr = 0;

  assign energyRd = kaRd | tRd;
  always #4 clk = ~clk;

  // Keep-alive reads so the watchdog stays quiet outside its own test
  always @(negedge clk) begin
    kaCnt <= kaCnt + 1;
    kaRd  <= wdKeep && (kaCnt % 8 == 0);
  end

  irqsc_top #(.WDOG_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .wrData(wrData), .evtPulse(evtPulse), .badCmd(badCmd),
    .portInit(portInit), .energyRd(energyRd), .statusRd(statusRd),
    .maskRd(maskRd), .irqN(irqN)
  );

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(logic sel, logic [23:0] d);
    regSel = sel; wrData = d; regWrEn = 1'b1;
    cyc(1);
    regWrEn = 1'b0; wrData = '0;
  endtask

  task automatic pulseEvt(logic [23:0] d);
    evtPulse = d;
    cyc(1);
    evtPulse = '0;
  endtask

  task automatic energyRead();
    tRd = 1'b1;
    cyc(1);
    tRd = 1'b0;
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    check("R1 status", statusRd, 24'h000001);
    check("R1 mask", maskRd, 24'h0);
    check("R1 irqN", {23'h0, irqN}, 24'h1);

    // R2/R3: single event positions, then clear all
    for (int i = 0; i < 24; i++) begin
      pulseEvt(24'h1 << i);
      check("R2 event sets", statusRd, 24'h1 | (EVT & (24'h1 << i)));
      wrReg(1'b0, 24'hFFFFFF);
      check("R3 clear all", statusRd, 24'h000001);
    end

    // R3 partial clears
    pulseEvt(24'hFFFFFF);
    check("R2 all events", statusRd, 24'hEBF81D);
    wrReg(1'b0, 24'h00F000);
    check("R3 partial clear", statusRd, 24'hEB081D);
    wrReg(1'b0, 24'h0);
    check("R3 zero write keeps", statusRd, 24'hEB081D);

    // R4 set wins
    evtPulse = 24'h800000;
    wrReg(1'b0, 24'hFFFFFF);
    evtPulse = '0;
    check("R4 set wins", statusRd, 24'h800001);
    wrReg(1'b0, 24'hFFFFFF);
    check("R2 masked still polls", {23'h0, irqN}, 24'h1);

    // R5 mask load
    wrReg(1'b1, 24'hA5A5A5);
    check("R5 mask load", maskRd, 24'hA5A5A5);
    cyc(1);
    check("R6 idle no irq", {23'h0, irqN}, 24'h1);

    // R6 single enable sweep
    for (int i = 0; i < 24; i++) begin
      wrReg(1'b1, 24'h1 << i);
      pulseEvt(24'h1 << i);
      cyc(1);
      check("R6 irq asserts", {23'h0, irqN}, {23'h0, ~EVT[i]});
      wrReg(1'b0, 24'hFFFFFF);
      cyc(1);
      check("R6 irq releases", {23'h0, irqN}, 24'h1);
    end

    // R7/R8 command-error flag
    wrReg(1'b1, 24'h000001);
    badCmd = 1'b1; cyc(1); badCmd = 1'b0;
    check("R7 fail clears", statusRd, 24'h0);
    cyc(1);
    check("R8 inverted irq", {23'h0, irqN}, 24'h0);
    wrReg(1'b0, 24'hFFFFFF);
    check("R7 write ignored", statusRd, 24'h0);
    portInit = 1'b1; cyc(1); portInit = 1'b0;
    check("R7 restore", statusRd, 24'h1);
    cyc(1);
    check("R8 irq released", {23'h0, irqN}, 24'h1);
    badCmd = 1'b1; portInit = 1'b1; cyc(1);
    badCmd = 1'b0; portInit = 1'b0;
    check("R7 fail wins", statusRd, 24'h0);
    portInit = 1'b1; cyc(1); portInit = 1'b0;
    check("R7 restore again", statusRd, 24'h1);

    // R9/R10 watchdog
    wrReg(1'b1, 24'h000020);
    wdKeep = 1'b0;
    cyc(2);
    energyRead();
    cyc(LIMIT);
    check("R9 not before limit", statusRd, 24'h1);
    cyc(1);
    check("R9 timeout sets", statusRd, 24'h21);
    cyc(1);
    check("R9 irq from wdt", {23'h0, irqN}, 24'h0);
    wrReg(1'b0, 24'h000020);
    check("R10 clear without read", statusRd, 24'h21);
    energyRead();
    wrReg(1'b0, 24'h000020);
    check("R10 clear after read", statusRd, 24'h1);
    cyc(LIMIT - 3);
    energyRead();
    cyc(LIMIT - 3);
    check("R9 read restarts", statusRd, 24'h1);
    wdKeep = 1'b1;
    cyc(2);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
    $finish;
  end
endmodule